// File: doc/BRIEF.md
# Single-Step Shift and Rotate Unit

This block moves an operand by exactly one bit position for the datapath of a small byte-wide processor. One 4-bit operation code selects one of ten variants: four left shifts, four right shifts, rotate left and rotate right. A left or right shift differs from its siblings only in the bit it pushes in at the vacated edge. That bit can be a constant 0, a constant 1, a copy of the edge bit that is being vacated, or the incoming carry flag. For every variant the bit pushed out at the far edge becomes the new carry. The new zero flag reports whether the result is all zeros.

The caller presents the operand, the current carry and zero flags and the operation code, and raises `in_valid` for one cycle. On the next rising clock edge the block captures the result and both new flags, and raises `out_valid` for that one cycle. When no valid input arrives, the outputs keep their last values. Codes that name no operation return the operand unchanged and hand back the incoming flags, so the caller can always write both flags back.

Top module: `srs_shift_unit`

## Requirements
- R1: For codes 0 to 3 (left shifts), result bits W-1..1 take operand bits W-2..0 and the new carry is operand bit W-1.
- R2: The left-shift fill into result bit 0 is 0 for code 0, 1 for code 1, operand bit 0 for code 2 and the incoming carry for code 3.
- R3: For codes 4 to 7 (right shifts), result bits W-2..0 take operand bits W-1..1 and the new carry is operand bit 0.
- R4: The right-shift fill into result bit W-1 is 0 for code 4, 1 for code 5, operand bit W-1 for code 6 and the incoming carry for code 7.
- R5: Code 8 rotates left, so operand bit W-1 goes to both result bit 0 and the carry. Code 9 rotates right, so operand bit 0 goes to both result bit W-1 and the carry.
- R6: For codes 0 to 9 the new zero flag is 1 exactly when the result is all zeros.
- R7: After code 1 or code 5 (one fill) the zero flag is always 0.
- R8: Codes 10 to 15 return the operand unchanged, with carry equal to `in_carry` and zero equal to `in_zero`.
- R9: An input with `in_valid` high appears at the outputs one clock later, with `out_valid` high for that single cycle. Without `in_valid`, `out_valid` is low and the data and flag outputs hold.
- R10: A synchronous active-high `rst` clears `out_valid`, `out_data`, `out_carry` and `out_zero` on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand and code are valid this cycle |
| in_op | input | 4 | Operation code (0..9 defined, 10..15 pass-through) |
| in_data | input | W (8) | Operand |
| in_carry | input | 1 | Current carry flag |
| in_zero | input | 1 | Current zero flag |
| out_valid | output | 1 | Result registered from the previous cycle's valid input |
| out_data | output | W (8) | Registered result |
| out_carry | output | 1 | Registered new carry |
| out_zero | output | 1 | Registered new zero |

## Verification
The bench goes after the fill bit of each variant, using operands whose edge bits differ from the incoming carry. A design with a swapped fill mux or a reversed direction would then show a wrong bit 0 or bit 7. It drives one-fill shifts of zero-like operands such as 0x00 and 0x80, where a zero detector that runs on the operand or ignores the fill would wrongly report zero. It also looks for a wrong flag on results that really are zero, such as a right shift of 0x01. Undefined codes are sent with flag values that differ from what any shift would produce, so a design that recomputed the flags would be exposed. Idle cycles and reset test that the outputs hold or clear rather than follow the inputs.

// File: rtl/srs_pkg.sv
package srs_pkg;

    localparam int SRS_OP_W = 4;

    // Operation codes
    localparam logic [SRS_OP_W-1:0] OPC_SHL_ZERO  = 4'd0;
    localparam logic [SRS_OP_W-1:0] OPC_SHL_ONE   = 4'd1;
    localparam logic [SRS_OP_W-1:0] OPC_SHL_EDGE  = 4'd2;
    localparam logic [SRS_OP_W-1:0] OPC_SHL_CARRY = 4'd3;
    localparam logic [SRS_OP_W-1:0] OPC_SHR_ZERO  = 4'd4;
    localparam logic [SRS_OP_W-1:0] OPC_SHR_ONE   = 4'd5;
    localparam logic [SRS_OP_W-1:0] OPC_SHR_EDGE  = 4'd6;
    localparam logic [SRS_OP_W-1:0] OPC_SHR_CARRY = 4'd7;
    localparam logic [SRS_OP_W-1:0] OPC_ROT_LEFT  = 4'd8;
    localparam logic [SRS_OP_W-1:0] OPC_ROT_RIGHT = 4'd9;
    localparam logic [SRS_OP_W-1:0] OPC_LAST_DEF  = OPC_ROT_RIGHT;

    // Which path supplies the result
    typedef enum logic [1:0] {
        KIND_LEFT  = 2'd0,
        KIND_RIGHT = 2'd1,
        KIND_PASS  = 2'd2
    } srs_kind_e;

    // Bit pushed into the vacated edge
    typedef enum logic [2:0] {
        FILL_ZERO  = 3'd0,
        FILL_ONE   = 3'd1,
        FILL_EDGE  = 3'd2,   // copy of the vacated edge bit
        FILL_CARRY = 3'd3,   // incoming carry
        FILL_WRAP  = 3'd4    // bit leaving the opposite edge (rotate)
    } srs_fill_e;

    typedef struct packed {
        srs_kind_e kind;
        srs_fill_e fill;
    } srs_ctl_t;

    function automatic logic srs_fill_bit(
        input srs_fill_e sel,
        input logic      edge_bit,
        input logic      wrap_bit,
        input logic      carry
    );
        logic b;
        case (sel)
            FILL_ZERO:  b = 1'b0;
            FILL_ONE:   b = 1'b1;
            FILL_EDGE:  b = edge_bit;
            FILL_CARRY: b = carry;
            FILL_WRAP:  b = wrap_bit;
            default:    b = 1'b0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/srs_op_decode.sv
module srs_op_decode
    import srs_pkg::*;
(
    input  logic [SRS_OP_W-1:0] op,
    output srs_ctl_t            ctl
);

    always_comb begin
        ctl.kind = KIND_PASS;
        ctl.fill = FILL_ZERO;
        case (op)
            OPC_SHL_ZERO:  begin ctl.kind = KIND_LEFT;  ctl.fill = FILL_ZERO;  end
            OPC_SHL_ONE:   begin ctl.kind = KIND_LEFT;  ctl.fill = FILL_ONE;   end
            OPC_SHL_EDGE:  begin ctl.kind = KIND_LEFT;  ctl.fill = FILL_EDGE;  end
            OPC_SHL_CARRY: begin ctl.kind = KIND_LEFT;  ctl.fill = FILL_CARRY; end
            OPC_SHR_ZERO:  begin ctl.kind = KIND_RIGHT; ctl.fill = FILL_ZERO;  end
            OPC_SHR_ONE:   begin ctl.kind = KIND_RIGHT; ctl.fill = FILL_ONE;   end
            OPC_SHR_EDGE:  begin ctl.kind = KIND_RIGHT; ctl.fill = FILL_EDGE;  end
            OPC_SHR_CARRY: begin ctl.kind = KIND_RIGHT; ctl.fill = FILL_CARRY; end
            OPC_ROT_LEFT:  begin ctl.kind = KIND_LEFT;  ctl.fill = FILL_WRAP;  end
            OPC_ROT_RIGHT: begin ctl.kind = KIND_RIGHT; ctl.fill = FILL_WRAP;  end
            default:       begin ctl.kind = KIND_PASS;  ctl.fill = FILL_ZERO;  end
        endcase
    end

endmodule

// File: rtl/srs_edge_shifter.sv
module srs_edge_shifter
    import srs_pkg::*;
#(
    parameter int W       = 8,
    parameter bit TO_LEFT = 1'b1
) (
    input  logic [W-1:0] data,
    input  srs_fill_e    fill_sel,
    input  logic         carry_in,
    output logic [W-1:0] res,
    output logic         carry_out
);

    localparam int MSB = W - 1;

    logic fill;

    generate
        if (TO_LEFT) begin : g_left
            // vacated edge is bit 0, departing edge is the MSB
            assign fill      = srs_fill_bit(fill_sel, data[0], data[MSB], carry_in);
            assign res       = {data[MSB-1:0], fill};
            assign carry_out = data[MSB];
        end else begin : g_right
            // vacated edge is the MSB, departing edge is bit 0
            assign fill      = srs_fill_bit(fill_sel, data[MSB], data[0], carry_in);
            assign res       = {fill, data[MSB:1]};
            assign carry_out = data[0];
        end
    endgenerate

endmodule

// File: rtl/srs_result_select.sv
module srs_result_select
    import srs_pkg::*;
#(
    parameter int W = 8
) (
    input  srs_kind_e    kind,
    input  logic [W-1:0] left_res,
    input  logic         left_carry,
    input  logic [W-1:0] right_res,
    input  logic         right_carry,
    input  logic [W-1:0] pass_data,
    input  logic         pass_carry,
    input  logic         pass_zero,
    output logic [W-1:0] res,
    output logic         carry,
    output logic         zero
);

    always_comb begin
        case (kind)
            KIND_LEFT: begin
                res   = left_res;
                carry = left_carry;
                zero  = ~|left_res;
            end
            KIND_RIGHT: begin
                res   = right_res;
                carry = right_carry;
                zero  = ~|right_res;
            end
            default: begin
                res   = pass_data;
                carry = pass_carry;
                zero  = pass_zero;
            end
        endcase
    end

endmodule

// File: rtl/srs_shift_unit.sv
module srs_shift_unit
    import srs_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [SRS_OP_W-1:0] in_op,
    input  logic [W-1:0]        in_data,
    input  logic                in_carry,
    input  logic                in_zero,
    output logic                out_valid,
    output logic [W-1:0]        out_data,
    output logic                out_carry,
    output logic                out_zero
);

    localparam int MSB = W - 1;

    srs_ctl_t     ctl;
    logic [W-1:0] l_res, r_res, nxt_res;
    logic         l_cy, r_cy, nxt_cy, nxt_z;

    srs_op_decode u_dec (
        .op  (in_op),
        .ctl (ctl)
    );

    srs_edge_shifter #(.W(W), .TO_LEFT(1'b1)) u_shl (
        .data      (in_data),
        .fill_sel  (ctl.fill),
        .carry_in  (in_carry),
        .res       (l_res),
        .carry_out (l_cy)
    );

    srs_edge_shifter #(.W(W), .TO_LEFT(1'b0)) u_shr (
        .data      (in_data),
        .fill_sel  (ctl.fill),
        .carry_in  (in_carry),
        .res       (r_res),
        .carry_out (r_cy)
    );

    srs_result_select #(.W(W)) u_sel (
        .kind        (ctl.kind),
        .left_res    (l_res),
        .left_carry  (l_cy),
        .right_res   (r_res),
        .right_carry (r_cy),
        .pass_data   (in_data),
        .pass_carry  (in_carry),
        .pass_zero   (in_zero),
        .res         (nxt_res),
        .carry       (nxt_cy),
        .zero        (nxt_z)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_carry <= 1'b0;
            out_zero  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data  <= nxt_res;
                out_carry <= nxt_cy;
                out_zero  <= nxt_z;
            end
        end
    end

    // R1: left shifts move bits up and send the MSB to carry
    p_left_move_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op <= OPC_SHL_CARRY) |=>
        (out_data[MSB:1] == $past(in_data[MSB-1:0]) && out_carry == $past(in_data[MSB])));

    // R2: left fill sources
    p_left_fill_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op <= OPC_SHL_CARRY) |=>
        (out_data[0] == (($past(in_op) == OPC_SHL_ZERO)  ? 1'b0 :
                         ($past(in_op) == OPC_SHL_ONE)   ? 1'b1 :
                         ($past(in_op) == OPC_SHL_EDGE)  ? $past(in_data[0]) :
                                                           $past(in_carry))));

    // R3: right shifts move bits down and send bit 0 to carry
    p_right_move_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op >= OPC_SHR_ZERO && in_op <= OPC_SHR_CARRY) |=>
        (out_data[MSB-1:0] == $past(in_data[MSB:1]) && out_carry == $past(in_data[0])));

    // R4: right fill sources
    p_right_fill_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op >= OPC_SHR_ZERO && in_op <= OPC_SHR_CARRY) |=>
        (out_data[MSB] == (($past(in_op) == OPC_SHR_ZERO) ? 1'b0 :
                           ($past(in_op) == OPC_SHR_ONE)  ? 1'b1 :
                           ($past(in_op) == OPC_SHR_EDGE) ? $past(in_data[MSB]) :
                                                            $past(in_carry))));

    // R5: rotates
    p_rotate_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_op == OPC_ROT_LEFT || in_op == OPC_ROT_RIGHT)) |=>
        (($past(in_op) == OPC_ROT_LEFT) ?
            (out_data == {$past(in_data[MSB-1:0]), $past(in_data[MSB])} && out_carry == $past(in_data[MSB])) :
            (out_data == {$past(in_data[0]), $past(in_data[MSB:1])} && out_carry == $past(in_data[0]))));

    // R6: zero flag tracks an all-zero result
    p_zero_flag_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op <= OPC_LAST_DEF) |=> (out_zero == (out_data == '0)));

    // R7: one fill never yields zero
    p_one_fill_nz_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_op == OPC_SHL_ONE || in_op == OPC_SHR_ONE)) |=> !out_zero);

    // R8: undefined codes pass data and flags
    p_pass_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op > OPC_LAST_DEF) |=>
        (out_data == $past(in_data) && out_carry == $past(in_carry) && out_zero == $past(in_zero)));

    // R9: one-cycle latency, hold when idle
    p_latency_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_data) && $stable(out_carry) && $stable(out_zero)));

    // R10: reset clears outputs
    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0 && !out_carry && !out_zero));

endmodule

// File: tb/srs_shift_unit_test.sv
module srs_shift_unit_test;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [3:0]   in_op = '0;
    logic [W-1:0] in_data = '0;
    logic         in_carry = 1'b0;
    logic         in_zero = 1'b0;
    logic         out_valid;
    logic [W-1:0] out_data;
    logic         out_carry;
    logic         out_zero;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    srs_shift_unit #(.W(W)) uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_op     (in_op),
        .in_data   (in_data),
        .in_carry  (in_carry),
        .in_zero   (in_zero),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_carry (out_carry),
        .out_zero  (out_zero)
    );

    // Expected {valid, zero, carry, data} from the requirement text
    function automatic logic [10:0] model(input logic [3:0] op, input logic [7:0] d,
                                          input logic c, input logic z);
        logic [7:0] r;
        logic       cy, zf;
        case (op)
            4'd0: begin r = {d[6:0], 1'b0}; cy = d[7]; end
            4'd1: begin r = {d[6:0], 1'b1}; cy = d[7]; end
            4'd2: begin r = {d[6:0], d[0]}; cy = d[7]; end
            4'd3: begin r = {d[6:0], c};    cy = d[7]; end
            4'd4: begin r = {1'b0, d[7:1]}; cy = d[0]; end
            4'd5: begin r = {1'b1, d[7:1]}; cy = d[0]; end
            4'd6: begin r = {d[7], d[7:1]}; cy = d[0]; end
            4'd7: begin r = {c, d[7:1]};    cy = d[0]; end
            4'd8: begin r = {d[6:0], d[7]}; cy = d[7]; end
            4'd9: begin r = {d[0], d[7:1]}; cy = d[0]; end
            default: begin r = d; cy = c; end
        endcase
        zf = (op <= 4'd9) ? (r == 8'h00) : z;
        return {1'b1, zf, cy, r};
    endfunction

    task automatic check(input string req, input logic [10:0] exp);
        logic [10:0] act;
        act = {out_valid, out_zero, out_carry, out_data};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual v/z/c/d=%b/%b/%b/%h expected %b/%b/%b/%h",
                     req, act[10], act[9], act[8], act[7:0], exp[10], exp[9], exp[8], exp[7:0]);
        end
    endtask

    // Drive one valid operation, check it one clock later
    task automatic run_op(input string req, input logic [3:0] op, input logic [7:0] d,
                          input logic c, input logic z);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_data = d; in_carry = c; in_zero = z;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, model(op, d, c, z));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 initial", 11'd0);
        rst = 1'b0;
        run_op("R10 pre", 4'd1, 8'hC3, 1'b1, 1'b0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R10 clear", 11'd0);
    endtask

    task automatic t_left();
        run_op("R1 R2 shl0", 4'd0, 8'hA5, 1'b1, 1'b0);
        run_op("R1 R2 shl1", 4'd1, 8'h5A, 1'b0, 1'b1);
        run_op("R1 R2 shl edge", 4'd2, 8'h81, 1'b0, 1'b0);
        run_op("R1 R2 shl edge0", 4'd2, 8'h7E, 1'b1, 1'b0);
        run_op("R1 R2 shl carry", 4'd3, 8'h40, 1'b1, 1'b0);
        run_op("R1 R2 shl carry0", 4'd3, 8'hFF, 1'b0, 1'b1);
    endtask

    task automatic t_right();
        run_op("R3 R4 shr0", 4'd4, 8'hA5, 1'b1, 1'b0);
        run_op("R3 R4 shr1", 4'd5, 8'h5A, 1'b0, 1'b1);
        run_op("R3 R4 shr sign", 4'd6, 8'h81, 1'b0, 1'b0);
        run_op("R3 R4 shr sign0", 4'd6, 8'h7E, 1'b1, 1'b0);
        run_op("R3 R4 shr carry", 4'd7, 8'h02, 1'b1, 1'b0);
        run_op("R3 R4 shr carry0", 4'd7, 8'hFF, 1'b0, 1'b1);
    endtask

    task automatic t_rotate();
        run_op("R5 rol", 4'd8, 8'h81, 1'b0, 1'b0);
        run_op("R5 rol", 4'd8, 8'h6C, 1'b1, 1'b1);
        run_op("R5 ror", 4'd9, 8'h01, 1'b0, 1'b0);
        run_op("R5 ror", 4'd9, 8'h36, 1'b1, 1'b1);
    endtask

    task automatic t_zero();
        run_op("R6 shl0 to zero", 4'd0, 8'h80, 1'b0, 1'b0);
        run_op("R6 shr0 to zero", 4'd4, 8'h01, 1'b1, 1'b0);
        run_op("R6 rol zero", 4'd8, 8'h00, 1'b1, 1'b0);
        run_op("R6 shr carry zero", 4'd7, 8'h01, 1'b0, 1'b0);
        run_op("R7 shl1 of 80", 4'd1, 8'h80, 1'b0, 1'b1);
        run_op("R7 shr1 of 00", 4'd5, 8'h00, 1'b0, 1'b1);
    endtask

    task automatic t_unused();
        for (int k = 10; k < 16; k++) begin
            run_op("R8 pass", 4'(k), 8'(8'h11 * k), k[0], ~k[0]);
        end
        run_op("R8 pass zero data", 4'd15, 8'h00, 1'b1, 1'b0);
    endtask

    task automatic t_hold();
        run_op("R9 load", 4'd2, 8'h3C, 1'b0, 1'b0);
        @(negedge clk);
        in_op = 4'd5; in_data = 8'hF0; in_carry = 1'b1; in_zero = 1'b1;
        @(negedge clk);
        check("R9 hold idle", {1'b0, model(4'd2, 8'h3C, 1'b0, 1'b0)} & 11'h3FF);
        @(negedge clk);
        check("R9 hold idle 2", {1'b0, model(4'd2, 8'h3C, 1'b0, 1'b0)} & 11'h3FF);
        // back-to-back valid inputs
        @(negedge clk);
        in_valid = 1'b1; in_op = 4'd0; in_data = 8'h11; in_carry = 1'b0; in_zero = 1'b0;
        @(negedge clk);
        check("R9 b2b first", model(4'd0, 8'h11, 1'b0, 1'b0));
        in_op = 4'd9; in_data = 8'h03; in_carry = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 b2b second", model(4'd9, 8'h03, 1'b0, 1'b0));
    endtask

    initial begin
        t_reset();
        t_left();
        t_right();
        t_rotate();
        t_zero();
        t_unused();
        t_hold();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule